// File: doc/BRIEF.md
# Rotating Output Shift Register With Word Refill

This block is the data shifter of a high-speed serial transmitter. It holds one word. Each active cycle it rotates that word right by a programmable number of bit positions, and the output lanes downstream pick their bits from the word. After a programmable number of rotate operations it takes a fresh word from an external input FIFO. The FIFO is reached through a valid signal from the FIFO and a pop strobe back to it.

A rotate, not a plain shift, is used. A left shift can therefore be obtained by rotating right by the word width minus the wanted distance. When the rotate distance times the operation count is more than the word width, the same bits come out again. A per-cycle shift strobe tells the transmit clock generator when the word has advanced.

The rotate distance and operation count are taken from their input pins only while the block is disabled. While the block is enabled they stay frozen. If the FIFO runs dry at a word boundary, the block stalls with the register held until the next word arrives.

Top module: `rot_shift_refill`

## Requirements
- R1: In a cycle with the shift strobe high and no pop, the register advances to its value rotated right by the captured rotate distance. The low bits move to the top and no zeros are filled in.
- R2: A loaded word stays in the register for exactly N cycles with the shift strobe high. The pop of the next word coincides with the N-th of those cycles. N is the captured operation count: a number of operations, not a bit distance.
- R3: A captured operation count of 0 means 32 operations per word.
- R4: When distance times count exceeds 32 the word wraps and repeats with no error. For example, distance 8 with count 8 brings the original word back after 4 rotates.
- R5: While enabled and the FIFO keeps supplying words, the shift strobe is high every cycle. Each new word is loaded on the last operation of the previous word, with no idle cycle between words.
- R6: While enable is low the pop strobe and the shift strobe stay low and the operation counter returns to its empty state. A word that was partly shifted is abandoned.
- R7: The rotate distance and operation count pins are sampled on every clock while enable is low and ignored while enable is high. After reset the captured values are distance 6 and count 5.
- R8: When the operation count is used up and the FIFO is not valid, the register holds its value and both strobes are low. The word is popped and loaded in the first cycle that valid is high.
- R9: After enable rises, the first cycle with a valid word pops and loads it with the shift strobe low. Shift strobes begin in the following cycle.
- R10: Reset clears the register to zero and empties the operation counter, so the shift strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run enable |
| rot_amt_i | input | 5 | Rotate-right distance, captured while disabled |
| shift_num_i | input | 5 | Operations per word (0 = 32), captured while disabled |
| fifo_data_i | input | 32 | Word at the head of the FIFO |
| fifo_valid_i | input | 1 | FIFO holds a word |
| sreg_o | output | 32 | Current register contents |
| fifo_pop_o | output | 1 | Takes the head word this cycle |
| shift_stb_o | output | 1 | Register advances this cycle |

## Verification
The hardest situation to reach is an underflow that lands exactly on a word boundary. It takes a FIFO that goes empty in the very cycle of the last operation, sometimes combined with enable dropping in the middle of a word and configuration pins that change while enabled. Directed sequences build each of these on purpose: a single word followed by an empty FIFO, an enable drop partway through a word, and configuration pins that toggle during a run. A long random phase with a fixed seed then varies valid, enable and the configuration pins every cycle. A cycle-by-cycle bench model compares every output on every cycle.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_LOAD  = 2'd2
    } rsr_act_e;
endpackage

// File: rtl/rsr_cfg_latch.sv
module rsr_cfg_latch #(
    parameter int ROT_W   = 5,
    parameter int RST_ROT = 6,
    parameter int RST_NSH = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic [ROT_W-1:0] rot_i,
    input  logic [ROT_W-1:0] nsh_i,
    output logic [ROT_W-1:0] rot_o,
    output logic [ROT_W-1:0] nsh_o
);
    typedef struct packed {
        logic [ROT_W-1:0] rot;
        logic [ROT_W-1:0] nsh;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!enable_i) begin
            cfg_d.rot = rot_i;
            cfg_d.nsh = nsh_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.rot <= ROT_W'(RST_ROT);
            cfg_q.nsh <= ROT_W'(RST_NSH);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rot_o = cfg_q.rot;
    assign nsh_o = cfg_q.nsh;

    // R7: captured settings only move while disabled
    p_cfg_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enable_i |=> ($stable(rot_o) && $stable(nsh_o)));
endmodule

// File: rtl/rsr_seq.sv
module rsr_seq #(
    parameter int ROT_W = 5,
    localparam int CNT_W = ROT_W + 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                enable_i,
    input  logic                valid_i,
    input  logic [ROT_W-1:0]    nsh_i,
    output logic                pop_o,
    output logic                shift_o,
    output rsr_pkg::rsr_act_e   act_o
);
    import rsr_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [CNT_W-1:0] load_cnt;
    logic             last_or_empty;

    always_comb begin
        load_cnt      = (nsh_i == '0) ? CNT_W'(1 << ROT_W) : {1'b0, nsh_i};
        last_or_empty = (seq_q.cnt <= CNT_W'(1));
        shift_o       = enable_i && (seq_q.cnt != '0);
        pop_o         = enable_i && valid_i && last_or_empty;
        seq_d         = seq_q;
        act_o         = ACT_HOLD;
        if (!enable_i) begin
            seq_d.cnt = '0;
        end else if (pop_o) begin
            seq_d.cnt = load_cnt;
            act_o     = ACT_LOAD;
        end else if (shift_o) begin
            seq_d.cnt = seq_q.cnt - CNT_W'(1);
            act_o     = ACT_SHIFT;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    // R6: a disabled cycle leaves no operations pending
    p_restart_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !shift_o);
    // R8: a pop is only issued against a valid head word
    p_pop_needs_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_o |-> valid_i);
    // R9: the cycle enable rises carries no shift strobe
    p_first_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(enable_i) |-> !shift_o);
endmodule

// File: rtl/rsr_rotator.sv
module rsr_rotator #(
    parameter int WIDTH = 32,
    localparam int ROT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [ROT_W-1:0] amt_i,
    output logic [WIDTH-1:0] data_o
);
    logic [WIDTH-1:0] stg [0:ROT_W];

    assign stg[0] = data_i;

    for (genvar s = 0; s < ROT_W; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stg[s+1] = amt_i[s] ? {stg[s][D-1:0], stg[s][WIDTH-1:D]} : stg[s];
    end

    assign data_o = stg[ROT_W];
endmodule

// File: rtl/rot_shift_refill.sv
module rot_shift_refill #(
    parameter int WIDTH   = 32,
    parameter int RST_ROT = 6,
    parameter int RST_NSH = 5,
    localparam int ROT_W = $clog2(WIDTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic [ROT_W-1:0] rot_amt_i,
    input  logic [ROT_W-1:0] shift_num_i,
    input  logic [WIDTH-1:0] fifo_data_i,
    input  logic             fifo_valid_i,
    output logic [WIDTH-1:0] sreg_o,
    output logic             fifo_pop_o,
    output logic             shift_stb_o
);
    import rsr_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] sreg;
    } top_t;

    top_t             st_d, st_q;
    logic [ROT_W-1:0] cfg_rot, cfg_nsh;
    logic [WIDTH-1:0] rotated;
    rsr_act_e         act;

    rsr_cfg_latch #(.ROT_W(ROT_W), .RST_ROT(RST_ROT), .RST_NSH(RST_NSH)) i_cfg (
        .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
        .rot_i(rot_amt_i), .nsh_i(shift_num_i),
        .rot_o(cfg_rot), .nsh_o(cfg_nsh)
    );

    rsr_seq #(.ROT_W(ROT_W)) i_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
        .valid_i(fifo_valid_i), .nsh_i(cfg_nsh),
        .pop_o(fifo_pop_o), .shift_o(shift_stb_o), .act_o(act)
    );

    rsr_rotator #(.WIDTH(WIDTH)) i_rot (
        .data_i(st_q.sreg), .amt_i(cfg_rot), .data_o(rotated)
    );

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_LOAD:  st_d.sreg = fifo_data_i;
            ACT_SHIFT: st_d.sreg = rotated;
            default:   st_d.sreg = st_q.sreg;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sreg_o = st_q.sreg;

    function automatic logic [WIDTH-1:0] ref_rotr(logic [WIDTH-1:0] v, logic [ROT_W-1:0] k);
        logic [2*WIDTH-1:0] t;
        t = {v, v} >> k;
        return t[WIDTH-1:0];
    endfunction

    // R1: a shift cycle rotates right by the captured distance
    p_rotate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_stb_o && !fifo_pop_o) |=> (sreg_o == ref_rotr($past(sreg_o), $past(cfg_rot))));
    // R5: a pop places the head word in the register
    p_load_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_pop_o |=> (sreg_o == $past(fifo_data_i)));
    // R8: without a shift or a pop the register holds
    p_hold_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!shift_stb_o && !fifo_pop_o) |=> $stable(sreg_o));
endmodule

// File: tb/test_rot_shift_refill.sv
module test_rot_shift_refill;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        vld = 1'b0;
    logic [4:0]  rot = '0;
    logic [4:0]  nsh = '0;
    logic [31:0] din = '0;
    logic [31:0] dout;
    logic        pop, shf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int pop_seen = 0;

    logic [31:0] m_reg;
    int          m_cnt;
    logic [4:0]  m_rot, m_nsh;

    always #2 clk = ~clk;

    rot_shift_refill i_rot_shift_refill (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(en),
        .rot_amt_i(rot), .shift_num_i(nsh),
        .fifo_data_i(din), .fifo_valid_i(vld),
        .sreg_o(dout), .fifo_pop_o(pop), .shift_stb_o(shf)
    );

    function automatic logic [31:0] rotr(logic [31:0] v, logic [4:0] k);
        logic [63:0] t;
        t = {v, v} >> k;
        return t[31:0];
    endfunction

    function automatic int expand_cnt(logic [4:0] n);
        return (n == 5'd0) ? 32 : int'(n);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(logic e, logic v, logic [31:0] d, logic [4:0] r, logic [4:0] n, string tag);
        logic e_shf, e_pop;
        @(negedge clk);
        en = e; vld = v; din = d; rot = r; nsh = n;
        #1;
        e_shf = e && (m_cnt != 0);
        e_pop = e && v && (m_cnt <= 1);
        chk(tag, dout, m_reg);
        chk(tag, 32'(shf), 32'(e_shf));
        chk(tag, 32'(pop), 32'(e_pop));
        if (pop) pop_seen++;
        @(posedge clk);
        if (!e) begin
            m_cnt = 0; m_rot = r; m_nsh = n;
        end else if (e_pop) begin
            m_reg = d; m_cnt = expand_cnt(m_nsh);
        end else if (e_shf) begin
            m_reg = rotr(m_reg, m_rot); m_cnt = m_cnt - 1;
        end
    endtask

    task automatic do_reset(logic e_during);
        rst_n = 1'b0; en = e_during; vld = e_during;
        din = 32'hFFFF_FFC0; rot = 5'd1; nsh = 5'd2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        m_reg = '0; m_cnt = 0; m_rot = 5'd6; m_nsh = 5'd5;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));

        // R10: reset state
        do_reset(1'b0);
        #1;
        chk("R10", dout, 32'h0);
        chk("R10", 32'(shf), 32'h0);
        chk("R10", 32'(pop), 32'h0);

        // R7: enable held high through reset uses distance 6, count 5; pins 1/2 ignored
        do_reset(1'b1);
        step(1, 1, 32'hFFFF_FFC0, 5'd1, 5'd2, "R7");
        step(1, 0, 32'h0, 5'd1, 5'd2, "R7");
        #1 chk("R7", dout, 32'h03FF_FFFF);
        pop_seen = 0;
        for (int i = 0; i < 10; i++) step(1, 1, 32'h1000_0000 + i, 5'd3, 5'd7, "R7");
        chk("R7", 32'(pop_seen), 32'd2);

        // R1: capture distance 4, then change pins while enabled (ignored)
        step(0, 0, 32'h0, 5'd4, 5'd3, "R6");
        step(1, 1, 32'h1234_5678, 5'd9, 5'd1, "R9");
        step(1, 0, 32'h0, 5'd9, 5'd1, "R1");
        #1 chk("R1", dout, 32'h8123_4567);
        step(1, 0, 32'h0, 5'd9, 5'd1, "R2");
        step(1, 0, 32'h0, 5'd9, 5'd1, "R8");
        step(1, 0, 32'h0, 5'd9, 5'd1, "R8");
        step(1, 1, 32'hDEAD_BEEF, 5'd9, 5'd1, "R8");

        // R4: distance 8 count 8 wraps back after four rotates
        step(0, 0, 32'h0, 5'd8, 5'd8, "R6");
        step(1, 1, 32'hAABB_CCDD, 5'd0, 5'd0, "R4");
        for (int i = 0; i < 4; i++) step(1, 0, 32'h0, 5'd0, 5'd0, "R4");
        #1 chk("R4", dout, 32'hAABB_CCDD);
        for (int i = 0; i < 6; i++) step(1, 0, 32'h0, 5'd0, 5'd0, "R4");

        // R3: count 0 means 32 operations per word
        step(0, 0, 32'h0, 5'd1, 5'd0, "R6");
        pop_seen = 0;
        for (int i = 0; i < 65; i++) step(1, 1, 32'h5A00_0000 ^ i, 5'd1, 5'd0, "R3");
        chk("R3", 32'(pop_seen), 32'd3);

        // R5: streaming with count 2, no idle cycle between words
        step(0, 0, 32'h0, 5'd3, 5'd2, "R6");
        pop_seen = 0;
        for (int i = 0; i < 21; i++) step(1, 1, $urandom, 5'd3, 5'd2, "R5");
        chk("R5", 32'(pop_seen), 32'd11);

        // R6: enable drop mid-word abandons the word; R9 reload first
        step(0, 0, 32'h0, 5'd5, 5'd6, "R6");
        step(1, 1, 32'h0F0F_0F0F, 5'd5, 5'd6, "R9");
        step(1, 1, 32'h0, 5'd5, 5'd6, "R6");
        step(1, 1, 32'h0, 5'd5, 5'd6, "R6");
        step(0, 1, 32'h0, 5'd5, 5'd6, "R6");
        step(0, 1, 32'h0, 5'd5, 5'd6, "R6");
        step(1, 1, 32'h7777_0001, 5'd5, 5'd6, "R9");
        step(1, 1, 32'h0, 5'd5, 5'd6, "R2");

        // Random mix: R2 counting, R7 ignored pins, R8 stalls
        for (int i = 0; i < 4000; i++)
            step(($urandom % 16) != 0, ($urandom % 4) != 0, $urandom,
                 5'($urandom), 5'($urandom % 9), "R2");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule